// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block sits beside the command arbiter of a DRAM controller and decides when an auto-refresh has to be sent to the device. A free-running interval timer produces one refresh obligation per average refresh period. A temperature-range input picks the normal period of 7.8 µs or the halved period of 3.9 µs used above 85 °C. Each obligation adds one to a debt counter. While the debt is non-zero the block asks the arbiter for a refresh slot. The arbiter may hold the request off while traffic is heavy. At most eight refreshes may be owed. At that limit the request is flagged urgent, and the count holds at the limit.

When the arbiter grants a refresh, the block opens a busy window that lasts the refresh cycle time. During that window no further refresh is requested and grants are ignored. A separate counter starts on each exit from self refresh and withholds read permission for a fixed number of clock cycles. All time values are given in nanoseconds together with the clock period, and the block converts them to whole clock cycles, rounding up.

Top module: `refresh_sched`

## Requirements
- R1: When rst_n is low at a rising clock edge, the block returns to its idle state at that edge. debt_cnt becomes 0, rfsh_req, rfsh_urgent and rfsh_busy go low, rd_allowed goes high, and the interval timer and both window counters are cleared.
- R2: With temp_hot low, the debt goes up by one every NORM rising edges, where NORM = ceil(TREFI_NORM_NS·1000/CLK_PS). The first increment happens at the NORM-th rising edge after reset is released.
- R3: With temp_hot high, the period is HOT = ceil(TREFI_HOT_NS·1000/CLK_PS) edges. If temp_hot rises when at least HOT−1 edges have passed since the last increment, the increment happens at the next edge.
- R4: rfsh_req is high exactly when debt_cnt is non-zero and rfsh_busy is low.
- R5: A grant is accepted only when rfsh_grant and rfsh_req are both high at an edge. An accepted grant lowers the debt by one. If an interval increment falls on the same edge, the debt is unchanged. A grant while rfsh_req is low has no effect, and the debt never goes below zero.
- R6: The debt saturates at MAX_POSTPONE (default 8). rfsh_urgent is high exactly while debt_cnt equals MAX_POSTPONE.
- R7: An accepted grant raises rfsh_busy for RFC = ceil(TRFC_NS·1000/CLK_PS) cycles, starting at the edge that accepted it. A grant held high during those cycles does not change debt_cnt.
- R8: A pulse on sref_exit drops rd_allowed at that edge, and rd_allowed stays low for XSRD_CYC cycles. A new pulse inside that window restarts the full wait.
- R9: debt_cnt never exceeds MAX_POSTPONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_hot | input | 1 | High selects the shortened high-temperature refresh period |
| rfsh_grant | input | 1 | Arbiter grants the refresh slot |
| sref_exit | input | 1 | One-cycle pulse when the device leaves self refresh |
| rfsh_req | output | 1 | A refresh is owed and may be granted |
| rfsh_urgent | output | 1 | Postponement limit reached |
| rfsh_busy | output | 1 | Refresh cycle time in progress |
| rd_allowed | output | 1 | Reads permitted (self-refresh exit wait is over) |
| debt_cnt | output | $clog2(MAX_POSTPONE+1) | Number of refreshes currently owed |

## Verification
The bench builds the block with a 4000 ps clock, a 200 ns normal period and a 100 ns hot period, which give 50 and 25 cycles, and a 20 ns refresh cycle time, which gives 5 cycles. The postponement limit stays at 8 and the exit wait stays at 200 cycles. These short periods let the bench fill the debt to saturation and hold it there, drain it with back-to-back grants, and land a grant on the same edge as an interval increment, all within a few hundred cycles. Every expected edge number is computed from these periods. Two further cases fit in the same run: a mid-interval switch of temp_hot, and a restart of the full exit wait.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Whole clock cycles covering a time in ns, rounded up.
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int NORM_CYC = 1950,
    parameter int HOT_CYC  = 975
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_sel,
    output logic tick
);
    localparam int CW = $clog2(rfsh_pkg::max_of(NORM_CYC, HOT_CYC) + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = hot_sel ? CW'(HOT_CYC - 1) : CW'(NORM_CYC - 1);
        tmr_d  = tmr_q;
        tick   = 1'b0;
        if (tmr_q.cnt >= lim_m1) begin
            tick      = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2, R3: obligations never come on consecutive edges.
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R2: the elapsed count stays below the longer period.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < CW'(rfsh_pkg::max_of(NORM_CYC, HOT_CYC)));

endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
    parameter  int MAX_DEBT = 8,
    localparam int DW       = $clog2(MAX_DEBT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] debt
);
    typedef struct packed {
        logic [DW-1:0] debt;
    } debt_t;

    debt_t debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        unique case ({inc, dec})
            2'b10: if (debt_q.debt != DW'(MAX_DEBT)) debt_d.debt = debt_q.debt + DW'(1);
            2'b01: if (debt_q.debt != '0)            debt_d.debt = debt_q.debt - DW'(1);
            default: debt_d = debt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) debt_q <= '0;
        else        debt_q <= debt_d;
    end

    assign debt = debt_q.debt;

    p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q.debt <= DW'(MAX_DEBT));
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (debt_q.debt == DW'(MAX_DEBT) && inc && !dec) |=> debt_q.debt == DW'(MAX_DEBT));
    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && debt_q.debt != '0) |=> debt_q.debt == $past(debt_q.debt) - DW'(1));

endmodule

// File: rtl/rfsh_window_timer.sv
module rfsh_window_timer #(
    parameter int LEN = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int WW = $clog2(LEN + 1);

    typedef struct packed {
        logic [WW-1:0] left;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (load)                win_d.left = WW'(LEN);
        else if (win_q.left != '0) win_d.left = win_q.left - WW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign active = (win_q.left != '0);

    // R7 (busy window) and R8 (exit wait): a load always opens the window.
    p_load_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter  int CLK_PS        = 4000,
    parameter  int TREFI_NORM_NS = 7800,
    parameter  int TREFI_HOT_NS  = 3900,
    parameter  int TRFC_NS       = 105,
    parameter  int XSRD_CYC      = 200,
    parameter  int MAX_POSTPONE  = 8,
    localparam int DW            = $clog2(MAX_POSTPONE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          temp_hot,
    input  logic          rfsh_grant,
    input  logic          sref_exit,
    output logic          rfsh_req,
    output logic          rfsh_urgent,
    output logic          rfsh_busy,
    output logic          rd_allowed,
    output logic [DW-1:0] debt_cnt
);
    localparam int NORM_CYC = rfsh_pkg::ns_to_cycles(TREFI_NORM_NS, CLK_PS);
    localparam int HOT_CYC  = rfsh_pkg::ns_to_cycles(TREFI_HOT_NS, CLK_PS);
    localparam int RFC_CYC  = rfsh_pkg::ns_to_cycles(TRFC_NS, CLK_PS);

    logic tick;
    logic grant_ok;
    logic exit_wait;

    rfsh_interval_timer #(.NORM_CYC(NORM_CYC), .HOT_CYC(HOT_CYC)) i_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_sel(temp_hot),
        .tick   (tick)
    );

    rfsh_debt_ctr #(.MAX_DEBT(MAX_POSTPONE)) i_debt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tick),
        .dec  (grant_ok),
        .debt (debt_cnt)
    );

    rfsh_window_timer #(.LEN(RFC_CYC)) i_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (grant_ok),
        .active(rfsh_busy)
    );

    rfsh_window_timer #(.LEN(XSRD_CYC)) i_exit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sref_exit),
        .active(exit_wait)
    );

    always_comb begin
        rfsh_req    = (debt_cnt != '0) && !rfsh_busy;
        rfsh_urgent = (debt_cnt == DW'(MAX_POSTPONE));
        grant_ok    = rfsh_grant && rfsh_req;
        rd_allowed  = !exit_wait;
    end

    p_grant_opens_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_grant && rfsh_req) |=> (rfsh_busy && !rfsh_req));
    p_busy_ignores_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_busy && rfsh_grant) |=> debt_cnt >= $past(debt_cnt));
    p_exit_blocks_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sref_exit |=> !rd_allowed);

endmodule

// File: tb/test_refresh_sched.sv
`timescale 1ns/1ps
module test_refresh_sched;
    localparam int CLK_PS = 4000;
    localparam int NS_N   = 200;
    localparam int NS_H   = 100;
    localparam int NS_RFC = 20;
    localparam int XS     = 200;
    localparam int MAXD   = 8;
    localparam int L      = (NS_N * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int H      = (NS_H * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RFC    = (NS_RFC * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic temp_hot = 1'b0;
    logic rfsh_grant = 1'b0;
    logic sref_exit = 1'b0;
    logic rfsh_req, rfsh_urgent, rfsh_busy, rd_allowed;
    logic [3:0] debt_cnt;

    int nchecks = 0;
    int nfail   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    refresh_sched #(
        .CLK_PS(CLK_PS), .TREFI_NORM_NS(NS_N), .TREFI_HOT_NS(NS_H),
        .TRFC_NS(NS_RFC), .XSRD_CYC(XS), .MAX_POSTPONE(MAXD)
    ) i_refresh_sched (
        .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .rfsh_grant(rfsh_grant),
        .sref_exit(sref_exit), .rfsh_req(rfsh_req), .rfsh_urgent(rfsh_urgent),
        .rfsh_busy(rfsh_busy), .rd_allowed(rd_allowed), .debt_cnt(debt_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R9 and R7 monitor, sampled at the falling edge.
    int  prev_debt = 0;
    bit  prev_busy_grant = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 debt bound", (debt_cnt <= MAXD) ? 1 : 0, 1);
            if (prev_busy_grant)
                check("R7 grant in busy window", (int'(debt_cnt) >= prev_debt) ? 1 : 0, 1);
        end
        prev_debt       = int'(debt_cnt);
        prev_busy_grant = rst_n && rfsh_busy && rfsh_grant;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(3);
        check("R1 debt", debt_cnt, 0);
        check("R1 req", rfsh_req, 0);
        check("R1 urgent", rfsh_urgent, 0);
        check("R1 busy", rfsh_busy, 0);
        check("R1 rd_allowed", rd_allowed, 1);
        rst_n = 1'b1;

        // R2 normal period, R6 saturation
        step(L - 1);
        check("R2 before first tick", debt_cnt, 0);
        check("R4 req idle", rfsh_req, 0);
        step(1);
        check("R2 first tick", debt_cnt, 1);
        check("R4 req owed", rfsh_req, 1);
        for (int k = 2; k <= MAXD; k++) begin
            step(L);
            check("R2 periodic tick", debt_cnt, k);
        end
        check("R6 urgent at limit", rfsh_urgent, 1);
        step(2 * L);
        check("R6 saturated", debt_cnt, MAXD);
        check("R6 urgent held", rfsh_urgent, 1);

        // R5, R7 grant and busy window (edge 10L+1 has no tick)
        rfsh_grant = 1'b1;
        step(1);
        check("R5 grant decrements", debt_cnt, MAXD - 1);
        check("R7 busy opens", rfsh_busy, 1);
        check("R4 req masked by busy", rfsh_req, 0);
        check("R6 urgent clears", rfsh_urgent, 0);
        step(RFC - 1);
        check("R7 busy last cycle", rfsh_busy, 1);
        check("R7 grant ignored in busy", debt_cnt, MAXD - 1);
        step(1);
        rfsh_grant = 1'b0;
        check("R7 busy closes", rfsh_busy, 0);
        check("R4 req returns", rfsh_req, 1);
        check("R7 debt after window", debt_cnt, MAXD - 1);

        // R5 grant on the same edge as a tick (edge 11L)
        step((11 * L - 1) - (10 * L + 1 + RFC));
        check("R5 before coincident edge", debt_cnt, MAXD - 1);
        rfsh_grant = 1'b1;
        step(1);
        rfsh_grant = 1'b0;
        check("R5 tick plus grant", debt_cnt, MAXD - 1);
        check("R5 coincident grant opens busy", rfsh_busy, 1);

        // R1 reset from a loaded state, R3 hot period
        rst_n = 1'b0;
        step(2);
        check("R1 debt cleared", debt_cnt, 0);
        check("R1 busy cleared", rfsh_busy, 0);
        temp_hot = 1'b1;
        rst_n = 1'b1;
        step(H - 1);
        check("R3 before hot tick", debt_cnt, 0);
        step(1);
        check("R3 hot tick", debt_cnt, 1);
        step(H);
        check("R3 second hot tick", debt_cnt, 2);

        // R3 switch to hot after the hot period already elapsed
        rst_n = 1'b0;
        temp_hot = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(H + 5);
        check("R3 normal not yet due", debt_cnt, 0);
        temp_hot = 1'b1;
        step(1);
        check("R3 switch ticks next edge", debt_cnt, 1);
        step(H - 1);
        check("R3 restart after switch", debt_cnt, 1);
        step(1);
        check("R3 hot period after switch", debt_cnt, 2);

        // R5 drain with grant held, then idle grant ignored
        rfsh_grant = 1'b1;
        step(1);
        check("R5 drain first", debt_cnt, 1);
        step(RFC + 1);
        check("R5 drain second", debt_cnt, 0);
        step(10);
        check("R5 idle grant no underflow", debt_cnt, 0);
        check("R5 idle no req", rfsh_req, 0);
        check("R5 idle no busy", rfsh_busy, 0);
        rfsh_grant = 1'b0;

        // R8 self-refresh exit wait
        sref_exit = 1'b1;
        step(1);
        sref_exit = 1'b0;
        check("R8 read blocked", rd_allowed, 0);
        step(XS - 1);
        check("R8 read blocked last", rd_allowed, 0);
        step(1);
        check("R8 read allowed", rd_allowed, 1);
        sref_exit = 1'b1;
        step(1);
        sref_exit = 1'b0;
        step(100);
        sref_exit = 1'b1;
        step(1);
        sref_exit = 1'b0;
        step(XS - 1);
        check("R8 restarted wait", rd_allowed, 0);
        step(1);
        check("R8 restarted wait ends", rd_allowed, 1);
        sref_exit = 1'b1;
        step(1);
        sref_exit = 1'b0;
        step(5);
        rst_n = 1'b0;
        step(1);
        check("R1 exit wait cleared", rd_allowed, 1);
        rst_n = 1'b1;
        step(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule